// File: doc/BRIEF.md
# Prioritised Interrupt Controller with Claim and Completion

This block gathers level-sensitive interrupt requests from a set of sources and routes them to a small number of processor contexts. Each source has a programmable priority. Each context has its own enable mask and a priority threshold, and the block raises one interrupt line per context.

A context is interrupted while at least one source qualifies for it. A qualifying source is pending, enabled for that context, and has a priority strictly above the context's threshold. Software in the interrupted context reads its claim register to learn which source to service. That read also clears the source's pending flag. The source's gateway then stays closed until software writes the same ID back to the same register. This write-back is the completion.

The only way in is a register port that finishes in one cycle. Read data is combinational from the address. Write data and the side effect of a claim read both take effect on the next rising clock edge.

Top module: `prio_irq_ctrl`

## Requirements
- R1: After reset every priority, enable bit and threshold is zero, no source is pending, and every `irq` bit is low.
- R2: The priority of source n sits at byte address 4*n, in bits [2:0]; wider write data is truncated. Source 0 does not exist: its address reads zero and ignores writes.
- R3: The 32-bit enable word k of context c sits at 0x2000 + 0x80*c + 4*k, and bit b of it enables source 32*k + b. Bit 0 of word 0 (source 0) always reads zero.
- R4: Context c has a control block at 0x200000 + 0x1000*c. The threshold (bits [2:0]) is at +0x0 and the claim/completion register is at +0x4.
- R5: A source qualifies for a context only if it is pending, enabled there, and its priority is strictly greater than that context's threshold. A priority of 0 never qualifies, and a threshold of 7 blocks everything.
- R6: Among the sources that qualify, the one with the highest priority wins. Equal priorities go to the lowest ID.
- R7: A read of a claim register returns the winning ID, or 0 when nothing qualifies. A nonzero result clears that source's pending flag on the same clock edge.
- R8: A gateway latches pending when its input is high and the source is not in flight. It then ignores the input until the source's ID is written to a claim/completion register. From the cycle after that write it can latch again.
- R9: A completion write of an ID that is not in flight, of 0, or of a value above the source count changes nothing.
- R10: The `irq` bit of each context follows that context's own qualification alone. It changes right after the edge that alters a pending flag, an enable bit, a priority or a threshold.
- R11: Addresses outside the register map, and misaligned addresses, read as zero. Writes to them leave all state unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| src_i | input | NSRC | Level interrupt requests, bit n is source n (n from 1) |
| addr | input | AW | Byte address of the register access |
| we | input | 1 | Write strobe |
| re | input | 1 | Read strobe (needed for claim side effect) |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data, combinational from addr |
| irq | output | NCTX | Interrupt request per context |

## Verification
The bench builds the block with its defaults: 31 sources, two contexts and 3-bit priorities. This makes every source ID and every pair of priority and threshold values reachable. For each source it sweeps all 64 priority/threshold pairs and checks the interrupt line against p > t. It then drains claims under several priority patterns and compares the order with an order it computes itself. The second context exposes any leakage between contexts. The single enable word exercises the edge of the map, where the next word and the next context block must read as empty.

// File: rtl/prio_irq_ctrl.sv
`timescale 1ns/1ps
module prio_irq_ctrl #(
  parameter int NSRC = 31,
  parameter int NCTX = 2,
  parameter int PW   = 3,
  parameter int AW   = 26
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NSRC:1]   src_i,
  input  logic [AW-1:0]   addr,
  input  logic            we,
  input  logic            re,
  input  logic [31:0]     wdata,
  output logic [31:0]     rdata,
  output logic [NCTX-1:0] irq
);
  localparam int IW = $clog2(NSRC + 1);
  localparam int CW = (NCTX > 1) ? $clog2(NCTX) : 1;
  localparam int NW = (NSRC + 32) / 32;
  localparam logic [31:0] PRIO_END  = 32'(4 * (NSRC + 1));
  localparam logic [31:0] EN_BASE   = 32'h2000;
  localparam logic [31:0] EN_END    = EN_BASE + 32'(32'h80 * NCTX);
  localparam logic [31:0] CT_BASE   = 32'h20_0000;
  localparam logic [31:0] CT_END    = CT_BASE + 32'(32'h1000 * NCTX);

  logic [PW-1:0] prio [1:NSRC];
  logic [NSRC:1] en   [NCTX];
  logic [PW-1:0] thr  [NCTX];
  logic [NSRC:1] pend, busy;
  logic [IW-1:0] best [NCTX];
  logic [PW-1:0] bp   [NCTX];

  logic [31:0]   a32;
  logic [IW-1:0] pidx, cid;
  logic [4:0]    en_word;
  logic [CW-1:0] en_ctx, ct_ctx;
  logic [11:0]   ct_reg;
  logic          hit_prio, hit_en, hit_ct, hit_thr, hit_clm;
  logic          claim_go, done_go;

  assign a32      = 32'(addr);
  assign pidx     = IW'(a32 >> 2);
  assign en_word  = 5'((a32 - EN_BASE) >> 2);
  assign en_ctx   = CW'((a32 - EN_BASE) >> 7);
  assign ct_ctx   = CW'((a32 - CT_BASE) >> 12);
  assign ct_reg   = 12'(a32 - CT_BASE);

  assign hit_prio = a32 < PRIO_END && a32[1:0] == 2'b00 && pidx != '0;
  assign hit_en   = a32 >= EN_BASE && a32 < EN_END && a32[1:0] == 2'b00
                    && 32'(en_word) < NW;
  assign hit_ct   = a32 >= CT_BASE && a32 < CT_END;
  assign hit_thr  = hit_ct && ct_reg == 12'h000;
  assign hit_clm  = hit_ct && ct_reg == 12'h004;

  assign cid      = IW'(wdata);
  assign claim_go = re && hit_clm && best[ct_ctx] != '0;
  assign done_go  = we && hit_clm && wdata != 32'd0 && wdata <= 32'(NSRC)
                    && busy[cid];

  always_comb begin
    for (int c = 0; c < NCTX; c++) begin
      bp[c]   = thr[c];
      best[c] = '0;
      for (int s = 1; s <= NSRC; s++) begin
        if (pend[s] && en[c][s] && prio[s] > bp[c]) begin
          bp[c]   = prio[s];
          best[c] = IW'(s);
        end
      end
      irq[c] = best[c] != '0;
    end
  end

  always_comb begin
    rdata = '0;
    if (hit_prio) rdata[PW-1:0] = prio[pidx];
    if (hit_en)
      for (int s = 1; s <= NSRC; s++)
        if (s / 32 == 32'(en_word)) rdata[s % 32] = en[en_ctx][s];
    if (hit_thr) rdata[PW-1:0] = thr[ct_ctx];
    if (hit_clm) rdata[IW-1:0] = best[ct_ctx];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int s = 1; s <= NSRC; s++) prio[s] <= '0;
      for (int c = 0; c < NCTX; c++) begin
        en[c]  <= '0;
        thr[c] <= '0;
      end
      pend <= '0;
      busy <= '0;
    end else begin
      if (we && hit_prio) prio[pidx] <= wdata[PW-1:0];
      if (we && hit_thr) thr[ct_ctx] <= wdata[PW-1:0];
      if (we && hit_en)
        for (int s = 1; s <= NSRC; s++)
          if (s / 32 == 32'(en_word)) en[en_ctx][s] <= wdata[s % 32];

      for (int s = 1; s <= NSRC; s++)
        if (src_i[s] && !busy[s]) begin
          pend[s] <= 1'b1;
          busy[s] <= 1'b1;
        end

      if (claim_go) pend[best[ct_ctx]] <= 1'b0;
      if (done_go)  busy[cid] <= 1'b0;
    end
  end
endmodule

// File: rtl/prio_irq_ctrl_chk.sv
`timescale 1ns/1ps
module prio_irq_ctrl_chk #(
  parameter int NSRC = 31,
  parameter int NCTX = 2,
  parameter int AW   = 26
) (
  input logic            clk,
  input logic            rst_n,
  input logic [AW-1:0]   addr,
  input logic            we,
  input logic            re,
  input logic [31:0]     wdata,
  input logic [31:0]     rdata,
  input logic [NCTX-1:0] irq,
  input logic [NSRC:1]   pend,
  input logic [NSRC:1]   busy
);
  localparam int IW = $clog2(NSRC + 1);
  localparam int CW = (NCTX > 1) ? $clog2(NCTX) : 1;
  localparam logic [31:0] CT_BASE = 32'h20_0000;
  localparam logic [31:0] CT_END  = CT_BASE + 32'(32'h1000 * NCTX);

  logic [31:0]   a32;
  logic          at_claim;
  logic [CW-1:0] cx;
  assign a32      = 32'(addr);
  assign at_claim = a32 >= CT_BASE && a32 < CT_END && 12'(a32 - CT_BASE) == 12'h004;
  assign cx       = CW'((a32 - CT_BASE) >> 12);

  a_r1_quiet_after_reset: assert property (@(posedge clk)
    $rose(rst_n) |-> irq == '0);

  a_r8_pend_in_flight: assert property (@(posedge clk) disable iff (!rst_n)
    (pend & ~busy) == '0);

  a_r10_irq_needs_pending: assert property (@(posedge clk) disable iff (!rst_n)
    irq != '0 |-> pend != '0);

  a_r7_empty_claim_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (re && at_claim && !irq[cx]) |-> rdata == 32'd0);

  a_r7_claim_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (re && at_claim && rdata != 32'd0) |=> !pend[$past(rdata[IW-1:0])]);

  for (genvar s = 1; s <= NSRC; s++) begin : g_src
    a_r9_release_only_by_done: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(busy[s]) |-> $past(we && at_claim && wdata == 32'(s)));
  end
endmodule

bind prio_irq_ctrl prio_irq_ctrl_chk #(.NSRC(NSRC), .NCTX(NCTX), .AW(AW)) u_chk (
  .clk(clk), .rst_n(rst_n), .addr(addr), .we(we), .re(re), .wdata(wdata),
  .rdata(rdata), .irq(irq), .pend(pend), .busy(busy));

// File: tb/sim_prio_irq_ctrl.sv
`timescale 1ns/1ps
module sim_prio_irq_ctrl;
  localparam int NSRC = 31;
  localparam int NCTX = 2;

  logic clk = 1'b0, rst_n = 1'b0, we = 1'b0, re = 1'b0;
  logic [NSRC:1] src = '0;
  logic [25:0] addr = '0;
  logic [31:0] wdata = '0, rdata, d;
  logic [NCTX-1:0] irq;
  int checks = 0, errors = 0;

  always #10 clk = ~clk;

  prio_irq_ctrl u0 (.clk(clk), .rst_n(rst_n), .src_i(src), .addr(addr), .we(we),
                    .re(re), .wdata(wdata), .rdata(rdata), .irq(irq));

  function automatic logic [25:0] a_pr(int n);  return 26'(4 * n); endfunction
  function automatic logic [25:0] a_en(int c, int k); return 26'(32'h2000 + 32'h80 * c + 4 * k); endfunction
  function automatic logic [25:0] a_th(int c);  return 26'(32'h20_0000 + 32'h1000 * c); endfunction
  function automatic logic [25:0] a_cl(int c);  return 26'(32'h20_0004 + 32'h1000 * c); endfunction

  task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s got %0h exp %0h", tag, got, exp);
    end
  endtask

  task automatic wr(input logic [25:0] a, input logic [31:0] v);
    @(negedge clk); addr = a; wdata = v; we = 1'b1;
    @(posedge clk); #1 we = 1'b0;
  endtask

  task automatic rd(input logic [25:0] a, output logic [31:0] v);
    @(negedge clk); addr = a; re = 1'b1; #2 v = rdata;
    @(posedge clk); #1 re = 1'b0;
  endtask

  task automatic settle(input int n);
    repeat (n) @(posedge clk);
    #5;
  endtask

  task automatic reset_dut;
    @(negedge clk); rst_n = 1'b0; src = '0;
    settle(2);
    @(negedge clk); rst_n = 1'b1;
    settle(1);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    reset_dut;
    // R1
    chk("R1 irq after reset", 32'(irq), 0);
    for (int n = 1; n <= NSRC; n++) begin rd(a_pr(n), d); chk("R1 prio reset", d, 0); end
    for (int c = 0; c < NCTX; c++) begin
      rd(a_en(c, 0), d); chk("R1 enable reset", d, 0);
      rd(a_th(c), d);    chk("R1 threshold reset", d, 0);
      rd(a_cl(c), d);    chk("R1 claim reset", d, 0);
    end

    // R2
    for (int n = 0; n <= NSRC; n++) wr(a_pr(n), 32'hFFFF_FFF8 | 32'((n * 5) % 8));
    rd(a_pr(0), d); chk("R2 source0 prio", d, 0);
    for (int n = 1; n <= NSRC; n++) begin rd(a_pr(n), d); chk("R2 prio readback", d, 32'((n * 5) % 8)); end

    // R3
    wr(a_en(0, 0), 32'hFFFF_FFFF);
    wr(a_en(1, 0), 32'h1234_5679);
    rd(a_en(0, 0), d); chk("R3 enable ctx0", d, 32'hFFFF_FFFE);
    rd(a_en(1, 0), d); chk("R3 enable ctx1", d, 32'h1234_5678);

    // R4
    wr(a_th(0), 32'h0000_00F5);
    wr(a_th(1), 32'd2);
    rd(a_th(0), d); chk("R4 threshold ctx0", d, 5);
    rd(a_th(1), d); chk("R4 threshold ctx1", d, 2);

    // R11
    wr(a_en(0, 1), 32'hFFFF_FFFF);
    wr(a_en(2, 0), 32'hFFFF_FFFF);
    wr(26'h0000_0082, 32'hFFFF_FFFF);
    wr(a_th(2), 32'd7);
    wr(26'h20_0008, 32'd7);
    rd(a_en(0, 1), d);  chk("R11 enable word1", d, 0);
    rd(a_en(2, 0), d);  chk("R11 enable ctx2", d, 0);
    rd(26'h0000_0082, d); chk("R11 misaligned", d, 0);
    rd(a_th(2), d);     chk("R11 ctrl ctx2", d, 0);
    rd(26'h20_0008, d); chk("R11 ctrl +8", d, 0);
    rd(26'h0000_0100, d); chk("R11 past prio", d, 0);
    rd(a_en(0, 0), d); chk("R11 enable intact", d, 32'hFFFF_FFFE);
    rd(a_pr(NSRC), d); chk("R11 prio intact", d, 32'((NSRC * 5) % 8));
    rd(a_th(1), d);    chk("R11 thr intact", d, 2);

    // R5 and R10 sweep
    reset_dut;
    wr(a_en(0, 0), 32'hFFFF_FFFE);
    for (int s = 1; s <= NSRC; s++) begin
      @(negedge clk); src = '0; src[s] = 1'b1;
      settle(2);
      for (int p = 0; p < 8; p++)
        for (int t = 0; t < 8; t++) begin
          wr(a_pr(s), 32'(p));
          wr(a_th(0), 32'(t));
          #5;
          chk(t == 7 ? "R5 threshold 7 blocks" : "R5 strict compare", 32'(irq[0]), 32'(p > t));
          chk("R10 other context idle", 32'(irq[1]), 0);
        end
      wr(a_th(0), 32'd0);
      @(negedge clk); src = '0;
      rd(a_cl(0), d); chk("R7 single claim", d, 32'(s));
      settle(1);
      chk("R7 irq after claim", 32'(irq[0]), 0);
      wr(a_cl(0), 32'(s));
    end

    // R6 and R7 claim order
    for (int k = 0; k < 4; k++) begin
      logic [NSRC:1] mp;
      int pr [1:NSRC];
      reset_dut;
      for (int s = 1; s <= NSRC; s++) begin
        pr[s] = (s * 3 + k * 5) % 8;
        wr(a_pr(s), 32'(pr[s]));
      end
      wr(a_en(0, 0), 32'hFFFF_FFFE);
      wr(a_th(0), 32'(k));
      @(negedge clk); src = '1;
      settle(2);
      @(negedge clk); src = '0;
      mp = '1;
      for (int i = 0; i <= NSRC; i++) begin
        int bid, bpr;
        bid = 0; bpr = k;
        for (int s = 1; s <= NSRC; s++)
          if (mp[s] && pr[s] > bpr) begin bpr = pr[s]; bid = s; end
        rd(a_cl(0), d);
        chk(bid == 0 ? "R7 drained claim" : "R6 claim order", d, 32'(bid));
        if (bid == 0) break;
        mp[bid] = 1'b0;
      end
    end

    // R8 and R9
    reset_dut;
    wr(a_pr(3), 32'd2);
    wr(a_en(0, 0), 32'h0000_0008);
    @(negedge clk); src[3] = 1'b1;
    settle(2);
    chk("R8 pending latched", 32'(irq), 1);
    rd(a_cl(0), d); chk("R8 claim id", d, 3);
    settle(4);
    chk("R8 blocked while in flight", 32'(irq), 0);
    rd(a_cl(0), d); chk("R8 no second claim", d, 0);
    wr(a_cl(0), 32'd4);
    wr(a_cl(0), 32'd0);
    wr(a_cl(0), 32'd35);
    settle(3);
    chk("R9 stray completions", 32'(irq), 0);
    wr(a_cl(0), 32'd3);
    settle(1);
    chk("R8 rearmed after completion", 32'(irq), 1);
    rd(a_cl(0), d); chk("R8 claim again", d, 3);
    @(negedge clk); src[3] = 1'b0;
    wr(a_cl(0), 32'd3);
    settle(3);
    chk("R8 no request when low", 32'(irq), 0);

    // R10 per-context routing
    reset_dut;
    for (int s = 1; s <= NSRC; s++) wr(a_pr(s), 32'd1);
    wr(a_en(0, 0), 32'h0000_0004);
    wr(a_en(1, 0), 32'h0000_0200);
    @(negedge clk); src[2] = 1'b1;
    settle(2);
    chk("R10 ctx0 only", 32'(irq), 1);
    rd(a_cl(1), d); chk("R10 ctx1 empty claim", d, 0);
    @(negedge clk); src[9] = 1'b1;
    settle(2);
    chk("R10 both contexts", 32'(irq), 3);
    rd(a_cl(1), d); chk("R10 ctx1 claim", d, 9);
    settle(1);
    chk("R10 ctx1 cleared", 32'(irq), 1);
    wr(a_en(0, 0), 32'd0);
    #5;
    chk("R10 disable drops line", 32'(irq), 0);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule